// File: doc/BRIEF.md
# Multi-Link Deskew Calibrator

This block receives several parallel chip-to-chip links that together carry one logical port, by default one control link and four data links. Each link reaches the receiver with its own skew, which may cross a clock boundary, yet the receiving logic must see every word of a transfer on one common target cycle. During calibration, the far end sends a fixed marker word on every link at the same moment. Each link measures how many cycles its copy of the marker lags a common start strobe.

After training, a worst-case vote takes the largest delay over all links, and every link is padded up to that value. A verify pass then waits for a second marker burst. It confirms that the marker now leaves every link's elastic buffer in the same cycle. On success the port locks and its aligned words are marked valid. If any link is off by a single cycle, or no marker arrives, calibration ends in a fail state. While the port is fenced, everything is frozen and arbitrary input on the wires has no effect.

Top module: `multilink_deskew`

## Requirements
- R1: While reset is asserted, `locked`, `failed` and `out_valid` are 0, and `meas_dly`, `voted_dly` and `aligned_out` are all zero.
- R2: `train_start` is accepted in idle, locked or fail. Training then runs for 2^DLY_W cycles, counted 0 upward from the cycle after the strobe. The first cycle k in which link i carries MARKER (default 8'hA5, link i in bits [i*DATA_W +: DATA_W]) sets that link's field `meas_dly[i*DLY_W +: DLY_W]` to k. Later markers in the same training are ignored. The result is readable in the cycle after training.
- R3: A link that shows no marker during training reports the saturated delay 2^DLY_W-1.
- R4: One cycle after training, a vote cycle sets `voted_dly` to the largest measured delay. It is readable from the first verify cycle.
- R5: From the vote on, link i adds `voted_dly - meas_i` cycles of padding, so its input appears on `aligned_out` after 1 + pad cycles. A word launched on all links at once therefore appears on every aligned output in the same cycle.
- R6: Verify lasts at most 3*2^DLY_W cycles. Its check window opens 2^DLY_W cycles after verify begins. If in some window cycle every aligned output equals MARKER, the port locks: from the next cycle `locked` and `out_valid` are 1.
- R7: If in a window cycle some aligned outputs equal MARKER but not all, `failed` is 1 from the next cycle.
- R8: If verify reaches its last cycle without any aligned marker, `failed` is 1 in the following cycle.
- R9: While `fence` is 1, the aligned outputs and measurements hold their values and `out_valid` is 0. Lane input is ignored, including marker words. A `train_start` is ignored as well, so a locked port stays locked.
- R10: A new `train_start` after lock or fail clears `locked`, `failed` and all measured delays in the first training cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_start | input | 1 | Strobe that starts calibration |
| fence | input | 1 | Port fenced: freeze and ignore lanes |
| lane_in | input | NUM_LINKS*DATA_W | Skewed words, link i in slice i |
| aligned_out | output | NUM_LINKS*DATA_W | Deskewed words, link i in slice i |
| out_valid | output | 1 | Aligned words valid (locked, not fenced) |
| meas_dly | output | NUM_LINKS*DLY_W | Per-link measured delay |
| voted_dly | output | DLY_W | Worst-case voted delay |
| locked | output | 1 | Calibration succeeded |
| failed | output | 1 | Calibration failed |

## Verification
A fence and a calibration strobe can fall in the same cycle. The bench raises `fence` and `train_start` together while the port is locked and fills the lanes with marker words. It then judges that the aligned words stay frozen, `out_valid` drops, and `locked` stays set once the fence lifts. A second collision happens inside the verify window, where one link's marker may land in the same cycle as the others or one cycle apart. Shifting a single link by one cycle must turn a would-be lock into a fail on exactly the cycle the first markers arrive.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TRAIN,
    ST_VOTE,
    ST_VERIFY,
    ST_LOCKED,
    ST_FAIL
  } cal_state_e;
endpackage

// File: rtl/deskew_lane.sv
module deskew_lane #(
  parameter int              DATA_W = 8,
  parameter int              DLY_W  = 3,
  parameter logic [DATA_W-1:0] MARKER = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  input  logic              train_clr,
  input  logic              train_act,
  input  logic              train_last,
  input  logic [DLY_W-1:0]  tcnt,
  input  logic              pad_load,
  input  logic [DLY_W-1:0]  vote_now,
  input  logic [DLY_W-1:0]  voted_ref,
  output logic [DLY_W-1:0]  meas_q,
  output logic [DLY_W-1:0]  pad_q,
  output logic [DATA_W-1:0] aligned_q,
  output logic              mark_hit
);
  localparam int DEPTH = 1 << DLY_W;
  localparam logic [DLY_W-1:0] MAX_DLY = '1;

  logic [DEPTH-1:0][DATA_W-1:0] mem_q;
  logic [DLY_W-1:0]             wp;
  logic                         found;
  logic [DLY_W-1:0]             rd_idx;
  logic                         din_is_mark;

  function automatic logic [DLY_W-1:0] pad_for(input logic [DLY_W-1:0] vote,
                                               input logic [DLY_W-1:0] meas);
    return vote - meas;
  endfunction

  assign rd_idx      = wp - pad_q;
  assign din_is_mark = (din == MARKER);
  assign mark_hit    = (aligned_q == MARKER);

  // delay measurement: first marker seen during training wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meas_q <= '0;
      found  <= 1'b0;
    end else if (train_clr) begin
      meas_q <= '0;
      found  <= 1'b0;
    end else if (train_act && !found) begin
      if (din_is_mark) begin
        meas_q <= tcnt;
        found  <= 1'b1;
      end else if (train_last) begin
        meas_q <= MAX_DLY;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        pad_q <= '0;
    else if (pad_load) pad_q <= pad_for(vote_now, meas_q);
  end

  // elastic buffer: circular store, read offset by the padding
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q     <= '0;
      wp        <= '0;
      aligned_q <= '0;
    end else if (en) begin
      mem_q[wp] <= din;
      wp        <= wp + 1'b1;
      aligned_q <= (pad_q == '0) ? din : mem_q[rd_idx];
    end
  end

  assert_fence_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(aligned_q) && $stable(meas_q)));

  assert_pad_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pad_load |=> (({1'b0, pad_q} + {1'b0, meas_q}) == {1'b0, voted_ref}));

  assert_meas_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!train_clr && !train_act) |=> $stable(meas_q));
endmodule

// File: rtl/deskew_ctrl.sv
module deskew_ctrl
  import deskew_pkg::*;
#(
  parameter int NUM_LINKS  = 5,
  parameter int DLY_W      = 3,
  parameter int VERIFY_LEN = 24,
  parameter int CNT_W      = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       train_start,
  input  logic [NUM_LINKS*DLY_W-1:0] meas_flat,
  input  logic [NUM_LINKS-1:0]       mark_hit,
  output logic [DLY_W-1:0]           tcnt,
  output logic                       train_clr,
  output logic                       train_act,
  output logic                       train_last,
  output logic                       pad_load,
  output logic [DLY_W-1:0]           vote_now,
  output logic [DLY_W-1:0]           voted_q,
  output logic                       locked,
  output logic                       failed
);
  localparam int DEPTH = 1 << DLY_W;
  localparam logic [DLY_W-1:0] MAX_DLY = '1;

  cal_state_e       st, st_nx;
  logic [CNT_W-1:0] vcnt;
  logic             start_ok, all_hit, any_hit, win_open, win_end;

  function automatic logic [DLY_W-1:0] worst_of(input logic [NUM_LINKS*DLY_W-1:0] v);
    logic [DLY_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_LINKS; i++)
      if (v[i*DLY_W +: DLY_W] > m) m = v[i*DLY_W +: DLY_W];
    return m;
  endfunction

  assign start_ok   = train_start && (st == ST_IDLE || st == ST_LOCKED || st == ST_FAIL);
  assign train_clr  = en && start_ok;
  assign train_act  = en && (st == ST_TRAIN);
  assign train_last = (tcnt == MAX_DLY);
  assign pad_load   = en && (st == ST_VOTE);
  assign vote_now   = worst_of(meas_flat);
  assign all_hit    = &mark_hit;
  assign any_hit    = |mark_hit;
  assign win_open   = (vcnt >= CNT_W'(DEPTH));
  assign win_end    = (vcnt == CNT_W'(VERIFY_LEN - 1));
  assign locked     = (st == ST_LOCKED);
  assign failed     = (st == ST_FAIL);

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE, ST_LOCKED, ST_FAIL: if (start_ok) st_nx = ST_TRAIN;
      ST_TRAIN:  if (train_last) st_nx = ST_VOTE;
      ST_VOTE:   st_nx = ST_VERIFY;
      ST_VERIFY: begin
        if (win_open && any_hit && !all_hit) st_nx = ST_FAIL;
        else if (win_open && all_hit)        st_nx = ST_LOCKED;
        else if (win_end)                    st_nx = ST_FAIL;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      tcnt    <= '0;
      vcnt    <= '0;
      voted_q <= '0;
    end else if (en) begin
      st <= st_nx;
      if (start_ok)                          tcnt <= '0;
      else if (st == ST_TRAIN && !train_last) tcnt <= tcnt + 1'b1;
      if (st == ST_VOTE) begin
        vcnt    <= '0;
        voted_q <= vote_now;
      end else if (st == ST_VERIFY) begin
        vcnt <= vcnt + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_vote_chk
    assert_vote_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_VERIFY) |-> (voted_q >= meas_flat[g*DLY_W +: DLY_W]));
  end

  assert_lock_on_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(all_hit));

  assert_restart_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    train_clr |=> (!locked && !failed));
endmodule

// File: rtl/multilink_deskew.sv
module multilink_deskew #(
  parameter int                NUM_LINKS = 5,
  parameter int                DATA_W    = 8,
  parameter int                DLY_W     = 3,
  parameter logic [DATA_W-1:0] MARKER    = 8'hA5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        train_start,
  input  logic                        fence,
  input  logic [NUM_LINKS*DATA_W-1:0] lane_in,
  output logic [NUM_LINKS*DATA_W-1:0] aligned_out,
  output logic                        out_valid,
  output logic [NUM_LINKS*DLY_W-1:0]  meas_dly,
  output logic [DLY_W-1:0]            voted_dly,
  output logic                        locked,
  output logic                        failed
);
  localparam int DEPTH      = 1 << DLY_W;
  localparam int VERIFY_LEN = 3 * DEPTH;
  localparam int CNT_W      = $clog2(VERIFY_LEN);

  logic                 en;
  logic [DLY_W-1:0]     tcnt, vote_now;
  logic                 train_clr, train_act, train_last, pad_load;
  logic [NUM_LINKS-1:0] mark_hit;

  assign en        = ~fence;
  assign out_valid = locked & ~fence;

  deskew_ctrl #(
    .NUM_LINKS(NUM_LINKS), .DLY_W(DLY_W), .VERIFY_LEN(VERIFY_LEN), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .train_start(train_start),
    .meas_flat(meas_dly), .mark_hit(mark_hit), .tcnt(tcnt),
    .train_clr(train_clr), .train_act(train_act), .train_last(train_last),
    .pad_load(pad_load), .vote_now(vote_now), .voted_q(voted_dly),
    .locked(locked), .failed(failed)
  );

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_lane
    logic [DLY_W-1:0] pad_unused;
    deskew_lane #(.DATA_W(DATA_W), .DLY_W(DLY_W), .MARKER(MARKER)) u_lane (
      .clk(clk), .rst_n(rst_n), .en(en),
      .din(lane_in[i*DATA_W +: DATA_W]),
      .train_clr(train_clr), .train_act(train_act), .train_last(train_last),
      .tcnt(tcnt), .pad_load(pad_load), .vote_now(vote_now), .voted_ref(voted_dly),
      .meas_q(meas_dly[i*DLY_W +: DLY_W]), .pad_q(pad_unused),
      .aligned_q(aligned_out[i*DATA_W +: DATA_W]), .mark_hit(mark_hit[i])
    );
  end
endmodule

// File: tb/multilink_deskew_tb.sv
`timescale 1ns/1ps
module multilink_deskew_tb;
  localparam int N = 5;
  localparam int W = 8;
  localparam int DW = 3;
  localparam logic [W-1:0] MARK = 8'hA5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, train_start, fence;
  logic [N*W-1:0]  lane_in, aligned_out;
  logic [N*DW-1:0] meas_dly;
  logic [DW-1:0]   voted_dly;
  logic out_valid, locked, failed;
  int checks = 0, fails = 0;
  bit done = 0;

  multilink_deskew u_dut (
    .clk(clk), .rst_n(rst_n), .train_start(train_start), .fence(fence),
    .lane_in(lane_in), .aligned_out(aligned_out), .out_valid(out_valid),
    .meas_dly(meas_dly), .voted_dly(voted_dly), .locked(locked), .failed(failed)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] filler(input int i, input int c);
    return W'(8'h10 + i + c);
  endfunction

  function automatic logic [W-1:0] src(input int x);
    return (x < 0) ? 8'h11 : W'(x * 13 + 5);
  endfunction

  function automatic int lane_out(input int i);
    return int'(aligned_out[i*W +: W]);
  endfunction

  function automatic int lane_meas(input int i);
    return int'(meas_dly[i*DW +: DW]);
  endfunction

  // mode 0: expect lock, 1: expect misalignment fail, 2: expect timeout fail
  task automatic run_cal(input int d[N], input bit [N-1:0] miss, input int sh[N],
                         input bit send, input int mode, input bit dup);
    int eff[N];
    int vmax = 0;
    for (int i = 0; i < N; i++) begin
      eff[i] = miss[i] ? 7 : d[i];
      if (eff[i] > vmax) vmax = eff[i];
    end
    train_start = 1'b1;
    for (int i = 0; i < N; i++) lane_in[i*W +: W] = filler(i, 0);
    @(negedge clk);
    train_start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (k == 0) begin
        chk(!locked && !failed, "R10", "lock/fail cleared on restart", {locked, failed}, 0);
        for (int i = 0; i < N; i++) chk(lane_meas(i) == 0, "R10", "meas cleared", lane_meas(i), 0);
      end
      for (int i = 0; i < N; i++)
        lane_in[i*W +: W] = ((!miss[i] && k == d[i]) || (dup && i == 0 && k == 7)) ? MARK : filler(i, k);
      @(negedge clk);
    end
    for (int i = 0; i < N; i++) begin
      lane_in[i*W +: W] = filler(i, 8);
      chk(lane_meas(i) == eff[i], miss[i] ? "R3" : "R2", "measured delay", lane_meas(i), eff[i]);
    end
    @(negedge clk);
    for (int c = 9; c < 35; c++) begin
      if (c == 9) chk(int'(voted_dly) == vmax, "R4", "voted delay", int'(voted_dly), vmax);
      for (int i = 0; i < N; i++)
        lane_in[i*W +: W] = (send && c == 17 + eff[i] + sh[i]) ? MARK : filler(i, c);
      if (mode == 0) begin
        if (c == 18 + vmax) begin
          for (int i = 0; i < N; i++) chk(lane_out(i) == MARK, "R5", "aligned marker", lane_out(i), MARK);
          chk(!locked, "R6", "not yet locked", locked, 0);
        end
        if (c == 19 + vmax) chk(locked && out_valid, "R6", "locked+valid", {locked, out_valid}, 3);
      end else if (mode == 1) begin
        if (c == 18 + vmax) chk(!failed, "R7", "not yet failed", failed, 0);
        if (c == 19 + vmax) chk(failed && !locked, "R7", "misalign fail", {failed, locked}, 2);
      end else begin
        if (c == 32) chk(!failed, "R8", "not yet timed out", failed, 0);
        if (c == 33) chk(failed && !locked, "R8", "timeout fail", {failed, locked}, 2);
      end
      @(negedge clk);
    end
  endtask

  task automatic stream_check(input int d[N], input int vmax);
    for (int c = 0; c < 16; c++) begin
      for (int i = 0; i < N; i++) lane_in[i*W +: W] = src(c - d[i]);
      if (c >= vmax + 1)
        for (int i = 0; i < N; i++)
          chk(lane_out(i) == int'(src(c - 1 - vmax)), "R5", "deskewed stream", lane_out(i), int'(src(c - 1 - vmax)));
      @(negedge clk);
    end
  endtask

  task automatic fence_check();
    logic [N*W-1:0]  held;
    logic [N*DW-1:0] mheld;
    held  = aligned_out;
    mheld = meas_dly;
    fence = 1'b1;
    train_start = 1'b1;
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < N; i++) lane_in[i*W +: W] = (k == 1) ? MARK : W'(8'hE0 + k * 5 + i);
      @(negedge clk);
      chk(aligned_out == held, "R9", "aligned held", 0, 0);
      chk(meas_dly == mheld, "R9", "meas held", int'(meas_dly), int'(mheld));
      chk(!out_valid && locked, "R9", "valid low, still locked", {out_valid, locked}, 1);
    end
    fence = 1'b0;
    train_start = 1'b0;
    @(negedge clk);
    chk(out_valid && locked, "R9", "valid after unfence", {out_valid, locked}, 3);
  endtask

  initial begin
    rst_n = 1'b0; train_start = 1'b0; fence = 1'b0; lane_in = '0;
    repeat (3) @(negedge clk);
    chk(!locked && !failed && !out_valid, "R1", "reset flags", {locked, failed, out_valid}, 0);
    chk(meas_dly == '0 && voted_dly == '0, "R1", "reset delays", int'(meas_dly), 0);
    chk(aligned_out == '0, "R1", "reset data", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // mixed skews, duplicate marker on link 0, then data and fence
    run_cal('{2, 0, 3, 1, 5}, 5'b00000, '{0, 0, 0, 0, 0}, 1'b1, 0, 1'b1);
    stream_check('{2, 0, 3, 1, 5}, 5);
    fence_check();
    // zero skew everywhere
    run_cal('{0, 0, 0, 0, 0}, 5'b00000, '{0, 0, 0, 0, 0}, 1'b1, 0, 1'b0);
    // one link off by one cycle in verify
    run_cal('{1, 4, 2, 6, 3}, 5'b00000, '{0, 0, 1, 0, 0}, 1'b1, 1, 1'b0);
    // a link with no training marker saturates, then locks
    run_cal('{3, 2, 1, 0, 0}, 5'b10000, '{0, 0, 0, 0, 0}, 1'b1, 0, 1'b0);
    stream_check('{3, 2, 1, 0, 7}, 7);
    // no verify burst: timeout
    run_cal('{1, 1, 2, 2, 3}, 5'b00000, '{0, 0, 0, 0, 0}, 1'b0, 2, 1'b0);
    // restart after fail
    run_cal('{4, 3, 2, 1, 0}, 5'b00000, '{0, 0, 0, 0, 0}, 1'b1, 0, 1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule